// File: doc/BRIEF.md
# Logical Shifter with Selectable Condition Flag

This block performs a zero-filling logical shift on a 32-bit operand and maintains the status bits that such a shift produces. A signed shift count picks the direction: a positive count shifts toward the most significant bit and a negative count shifts toward the least significant bit. A count whose magnitude reaches the data width empties the word. The shifted word leaves the block combinationally, along with a result-write strobe that the surrounding datapath uses to commit it.

The status register holds five flag bits and a 3-bit mode field. The mode field decides what the general-purpose condition flag (`sr_dc`) reports. It can report the last bit that left the word, the sign bit, a zero test, or a forced zero. The sign flag and the zero flag always track the result, whatever the mode field holds. The overflow and greater-than flags are cleared by every flag update. An unconditional operation updates all five flags. A conditional operation only produces a result write, and only when its condition input is true; it never changes the flags.

The mode field is loaded through its own write enable. An operation issued in the same cycle as a mode write is judged under the mode that was in force before that clock edge.

Top module: `lsf_top`

## Requirements
- R1: A positive `shamt` (two's complement, 6 bits) shifts `operand` left by that count, and zeros fill the vacated low bits.
- R2: A negative `shamt` shifts right by its magnitude, and zeros fill the vacated high bits. A magnitude of 32 or more gives a result of 0.
- R3: A `shamt` of 0 returns `operand` unchanged and gives a carry-mode condition flag of 0.
- R4: With mode 3'b000, `sr_dc` is loaded with the last bit shifted out. For a left shift by k this is operand bit 32-k; for a right shift by k it is operand bit k-1.
- R5: With mode 3'b001, `sr_dc` is loaded with result bit 31. `sr_n` is always loaded with result bit 31.
- R6: With mode 3'b010, `sr_dc` is loaded with 1 when the result is all zeros and 0 otherwise. `sr_z` is always loaded with that same zero test.
- R7: With modes 3'b011 to 3'b111, `sr_dc` is loaded with 0. Every flag update clears `sr_v` and `sr_gt`.
- R8: When `op_valid`=1 and `is_cond`=0, all five flags take their new values at the next clock edge, and `res_we`=1.
- R9: When `op_valid`=1 and `is_cond`=1, the five flags keep their values, and `res_we` equals `cond_true`. When `op_valid`=0, the flags keep their values and `res_we`=0.
- R10: `mode_we`=1 loads `mode_in` into `sr_mode` at the clock edge. An operation in that same cycle computes `sr_dc` under the previous mode.
- R11: Synchronous reset (`rst`=1) clears all five flags and sets `sr_mode` to 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A shift operation is issued this cycle |
| is_cond | input | 1 | The issued operation is conditional |
| cond_true | input | 1 | Outcome of the condition of a conditional operation |
| operand | input | 32 | Data word to shift |
| shamt | input | 6 | Signed shift count: positive shifts left, negative shifts right |
| mode_we | input | 1 | Load enable for the mode field |
| mode_in | input | 3 | New value for the mode field |
| result | output | 32 | Shifted word (combinational) |
| res_we | output | 1 | Strobe that commits the result |
| sr_dc | output | 1 | Condition flag selected by the mode field |
| sr_n | output | 1 | Sign flag |
| sr_z | output | 1 | Zero flag |
| sr_v | output | 1 | Overflow flag (cleared by shifts) |
| sr_gt | output | 1 | Greater-than flag (cleared by shifts) |
| sr_mode | output | 3 | Mode field |

## Verification
A mode-field write and a flag-updating shift can land on the same clock edge. In that case the shift must be judged under the old mode, while the mode field takes the new value. The bench sets up this collision with a right shift of 1 applied to the value 1, under mode 3'b000, while it writes mode 3'b001. The last bit shifted out is 1, but bit 31 of the result is 0, so `sr_dc` shows which mode was applied. After that edge, `sr_mode` must read back 3'b001.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  typedef enum logic [2:0] {
    MODE_CARRY = 3'b000,
    MODE_NEG   = 3'b001,
    MODE_ZERO  = 3'b010,
    MODE_OVF   = 3'b011,
    MODE_GT    = 3'b100,
    MODE_GE    = 3'b101,
    MODE_RSV6  = 3'b110,
    MODE_RSV7  = 3'b111
  } mode_e;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } flags_t;

  localparam flags_t FLAGS_CLEAR = '{dc: 1'b0, n: 1'b0, z: 1'b0, v: 1'b0, gt: 1'b0};

endpackage

// File: rtl/lsf_shifter.sv
module lsf_shifter #(
  parameter int W   = 32,
  parameter int SHW = 6
) (
  input  logic [W-1:0]   operand,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   result,
  output logic           last_out
);
  localparam int KW = $clog2(W + 1);
  localparam logic [SHW:0] WLIM = (SHW + 1)'(W);

  logic           go_right;
  logic [SHW:0]   mag_raw;
  logic [KW-1:0]  kamt;
  logic [W:0]     left_t;
  logic [W:0]     right_t;

  // Magnitude of the signed count, one bit wider so -2^(SHW-1) fits
  always_comb begin
    go_right = shamt[SHW-1];
    if (go_right) mag_raw = {1'b0, ~shamt} + 1'b1;
    else          mag_raw = {1'b0, shamt};
    if (mag_raw >= WLIM) kamt = KW'(W);
    else                 kamt = mag_raw[KW-1:0];
  end

  // One guard bit on the exit side captures the last bit shifted out
  always_comb begin
    left_t  = {1'b0, operand} << kamt;
    right_t = {operand, 1'b0} >> kamt;
    if (kamt == '0) begin
      result   = operand;
      last_out = 1'b0;
    end else if (go_right) begin
      result   = right_t[W:1];
      last_out = right_t[0];
    end else begin
      result   = left_t[W-1:0];
      last_out = left_t[W];
    end
  end

  always_comb begin
    if (kamt == '0) a_r3_zero_count: assert (result == operand && !last_out);
  end

endmodule

// File: rtl/lsf_flag_sel.sv
module lsf_flag_sel
  import lsf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] result,
  input  logic         last_out,
  input  logic [2:0]   mode,
  output flags_t       next_flags
);
  logic is_zero;
  logic sign;

  assign is_zero = (result == '0);
  assign sign    = result[W-1];

  always_comb begin
    next_flags    = FLAGS_CLEAR;
    next_flags.n  = sign;
    next_flags.z  = is_zero;
    next_flags.v  = 1'b0;
    next_flags.gt = 1'b0;
    case (mode_e'(mode))
      MODE_CARRY: next_flags.dc = last_out;
      MODE_NEG:   next_flags.dc = sign;
      MODE_ZERO:  next_flags.dc = is_zero;
      default:    next_flags.dc = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsf_status_reg.sv
module lsf_status_reg
  import lsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flag_we,
  input  flags_t     flags_d,
  input  logic       mode_we,
  input  logic [2:0] mode_d,
  output flags_t     flags_q,
  output logic [2:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= FLAGS_CLEAR;
      mode_q  <= MODE_CARRY;
    end else begin
      if (flag_we) flags_q <= flags_d;
      if (mode_we) mode_q  <= mode_d;
    end
  end

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_q));

  a_r10_mode_load: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> mode_q == $past(mode_d));

  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> flags_q == FLAGS_CLEAR && mode_q == 3'b000);

endmodule

// File: rtl/lsf_top.sv
module lsf_top
  import lsf_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = 6,
  parameter int MW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic           is_cond,
  input  logic           cond_true,
  input  logic [W-1:0]   operand,
  input  logic [SHW-1:0] shamt,
  input  logic           mode_we,
  input  logic [MW-1:0]  mode_in,
  output logic [W-1:0]   result,
  output logic           res_we,
  output logic           sr_dc,
  output logic           sr_n,
  output logic           sr_z,
  output logic           sr_v,
  output logic           sr_gt,
  output logic [MW-1:0]  sr_mode
);
  logic   last_out;
  logic   flag_we;
  flags_t next_flags;
  flags_t flags_q;

  lsf_shifter #(.W(W), .SHW(SHW)) u_shift (
    .operand (operand),
    .shamt   (shamt),
    .result  (result),
    .last_out(last_out)
  );

  lsf_flag_sel #(.W(W)) u_sel (
    .result    (result),
    .last_out  (last_out),
    .mode      (sr_mode),
    .next_flags(next_flags)
  );

  // Flags only follow unconditional operations; results follow either kind
  assign flag_we = op_valid && !is_cond;
  assign res_we  = op_valid && (!is_cond || cond_true);

  lsf_status_reg u_sr (
    .clk    (clk),
    .rst    (rst),
    .flag_we(flag_we),
    .flags_d(next_flags),
    .mode_we(mode_we),
    .mode_d (mode_in),
    .flags_q(flags_q),
    .mode_q (sr_mode)
  );

  assign sr_dc = flags_q.dc;
  assign sr_n  = flags_q.n;
  assign sr_z  = flags_q.z;
  assign sr_v  = flags_q.v;
  assign sr_gt = flags_q.gt;

  a_r5_sign_flag: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> sr_n == $past(result[W-1]));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> sr_z == ($past(result) == '0));

  a_r7_vgt_cleared: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> !sr_v && !sr_gt);

  a_r7_dc_forced: assert property (@(posedge clk) disable iff (rst)
    flag_we && sr_mode >= 3'b011 |=> !sr_dc);

  a_r9_cond_commit: assert property (@(posedge clk) disable iff (rst)
    op_valid && is_cond |-> res_we == cond_true);

endmodule

// File: tb/sim_lsf_top.sv
`timescale 1ns/1ps
module sim_lsf_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, is_cond, cond_true, mode_we;
  logic [31:0] operand;
  logic [5:0]  shamt;
  logic [2:0]  mode_in;
  logic [31:0] result;
  logic        res_we, sr_dc, sr_n, sr_z, sr_v, sr_gt;
  logic [2:0]  sr_mode;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lsf_top u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .is_cond(is_cond),
    .cond_true(cond_true), .operand(operand), .shamt(shamt),
    .mode_we(mode_we), .mode_in(mode_in), .result(result), .res_we(res_we),
    .sr_dc(sr_dc), .sr_n(sr_n), .sr_z(sr_z), .sr_v(sr_v), .sr_gt(sr_gt),
    .sr_mode(sr_mode)
  );

  // mode, shamt, operand, expected result, expected {dc,n,z}
  localparam int NV = 13;
  localparam logic [75:0] VEC [NV] = '{
    {3'd0, 6'd4,  32'hF000_0001, 32'h0000_0010, 3'b100},
    {3'd0, 6'h3F, 32'h0000_0003, 32'h0000_0001, 3'b100},
    {3'd0, 6'd0,  32'h8000_0001, 32'h8000_0001, 3'b010},
    {3'd1, 6'd31, 32'h0000_0001, 32'h8000_0000, 3'b110},
    {3'd2, 6'h20, 32'hFFFF_FFFF, 32'h0000_0000, 3'b101},
    {3'd2, 6'd8,  32'h1234_5678, 32'h3456_7800, 3'b000},
    {3'd3, 6'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFE, 3'b010},
    {3'd4, 6'h3C, 32'h0000_000F, 32'h0000_0000, 3'b001},
    {3'd5, 6'd2,  32'h4000_0000, 32'h0000_0000, 3'b001},
    {3'd6, 6'h21, 32'h8000_0000, 32'h0000_0001, 3'b000},
    {3'd7, 6'd16, 32'h0000_8000, 32'h8000_0000, 3'b010},
    {3'd0, 6'h20, 32'h8000_0000, 32'h0000_0000, 3'b101},
    {3'd0, 6'd31, 32'h0000_0002, 32'h0000_0000, 3'b101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; is_cond = 0; cond_true = 0; mode_we = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1; idle(); operand = '0; shamt = '0; mode_in = '0;
    @(negedge clk); tick(); rst = 0;
    #1;
    chk("R11 flags after reset", {27'd0, sr_dc, sr_n, sr_z, sr_v, sr_gt}, 32'd0);
    chk("R11 mode after reset", {29'd0, sr_mode}, 32'd0);
    chk("R9 res_we idle", {31'd0, res_we}, 32'd0);

    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      idle(); mode_we = 1; mode_in = VEC[i][75:73];
      tick();
      idle(); op_valid = 1;
      shamt = VEC[i][72:67]; operand = VEC[i][66:35];
      #1;
      chk($sformatf("R1/R2/R3 result vec%0d", i), result, VEC[i][34:3]);
      chk($sformatf("R8 res_we vec%0d", i), {31'd0, res_we}, 32'd1);
      @(posedge clk); #1;
      chk($sformatf("R4/R5/R6/R7 dc,n,z vec%0d", i), {29'd0, sr_dc, sr_n, sr_z}, {29'd0, VEC[i][2:0]});
      chk($sformatf("R7 v,gt vec%0d", i), {30'd0, sr_v, sr_gt}, 32'd0);
      @(negedge clk);
    end

    // Put known flags in place: mode 001, shift 1 left by 31 -> dc=1 n=1 z=0
    idle(); mode_we = 1; mode_in = 3'b001; tick();
    idle(); op_valid = 1; shamt = 6'd31; operand = 32'h1; tick();
    chk("R8 setup flags", {29'd0, sr_dc, sr_n, sr_z}, 32'b110);

    // Conditional, condition true: result commits, flags stay
    idle(); op_valid = 1; is_cond = 1; cond_true = 1; shamt = 6'h20; operand = 32'hFFFF_FFFF;
    #1;
    chk("R9 cond true res_we", {31'd0, res_we}, 32'd1);
    chk("R9 cond true result", result, 32'd0);
    tick();
    chk("R9 cond true flags held", {27'd0, sr_dc, sr_n, sr_z, sr_v, sr_gt}, 32'b11000);

    // Conditional, condition false
    idle(); op_valid = 1; is_cond = 1; cond_true = 0; shamt = 6'd0; operand = 32'h0;
    #1;
    chk("R9 cond false res_we", {31'd0, res_we}, 32'd0);
    tick();
    chk("R9 cond false flags held", {27'd0, sr_dc, sr_n, sr_z, sr_v, sr_gt}, 32'b11000);

    // No operation issued
    idle(); shamt = 6'h20; operand = 32'h0; tick();
    chk("R9 idle flags held", {27'd0, sr_dc, sr_n, sr_z, sr_v, sr_gt}, 32'b11000);

    // Mode write and operation on the same edge: old mode 000 applies
    idle(); mode_we = 1; mode_in = 3'b000; tick();
    idle(); op_valid = 1; shamt = 6'h3F; operand = 32'h1; mode_we = 1; mode_in = 3'b001;
    tick();
    chk("R10 dc under old mode", {31'd0, sr_dc}, 32'd1);
    chk("R10 new mode loaded", {29'd0, sr_mode}, 32'd1);

    // Reset in mid-run
    idle(); mode_we = 1; mode_in = 3'b101; tick();
    idle(); rst = 1; tick(); rst = 0;
    chk("R11 flags after mid reset", {27'd0, sr_dc, sr_n, sr_z, sr_v, sr_gt}, 32'd0);
    chk("R11 mode after mid reset", {29'd0, sr_mode}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule